// File: doc/BRIEF.md
# Bundle Issue Sequencer

This block walks one very-long-instruction-word bundle from memory into an execution pipeline. After a start request it fetches 32-bit words from the current program counter, one fetch handshake per word. It hands each word to the decode and execute side through an issue handshake, and moves the program counter to the address that execution reports. A bundle ends after the word whose top bit is set, or once the configured number of slots has been issued, whichever comes first.

For each issued word the sequencer marks whether it is the leading word of the bundle. It pulses a strobe that tells the register file to zero general register 0 ahead of execution. It also remembers the most recent media-unit slot that execution assigned within the bundle. When a bundle closes it requests the deferred write commit. After that handshake it adds the bundle's word count to a running instruction total and raises a one-cycle completion pulse. A cycle tally accumulates each word's cost: zero for internal (virtual) words, the timing-model cycle count when one is supplied, and one otherwise.

Top module: `bundle_seq`

## Requirements
- R1: After reset, fetch_req, issue_valid, commit_req, done and gr0_clr are low, insn_count and cycle_count are zero and media_slot holds the nil code 0.
- R2: A start accepted in idle loads start_pc; every fetch_addr equals the current program counter, and once a word is acknowledged it appears on issue_word with issue_pc equal to its fetch address.
- R3: A word with bit 31 set is the last of its bundle: after its exec_done the sequencer raises commit_req, otherwise it raises fetch_req for the next word.
- R4: issue_slot counts 0,1,2,... within a bundle and never reaches MAX_SLOTS; after the slot MAX_SLOTS-1 completes, the bundle closes even with bit 31 clear.
- R5: issue_first is high for slot 0 of each bundle and low for every later slot.
- R6: gr0_clr is high for exactly the first cycle of each issue and low otherwise.
- R7: media_slot returns to 0 when a bundle starts, and takes exec_unit whenever that code lies in the media range 8 to 11 at exec_done; other codes leave it unchanged.
- R8: After exec_done, cur_pc equals exec_target when exec_branch is high, and the previous value plus 4 otherwise.
- R9: done is high for exactly one cycle, in the cycle after the commit_req/commit_ack handshake, and from that cycle insn_count includes the number of words issued in the bundle.
- R10: At each exec_done, cycle_count grows by 0 when exec_virtual is high, by exec_cycles when exec_timed is high, and by 1 otherwise.
- R11: start is ignored in every state other than idle, including the done cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Begin a bundle (accepted only in idle) |
| start_pc | input | AW | Address of the bundle's first word |
| fetch_req | output | 1 | Word fetch request |
| fetch_addr | output | AW | Address of the word requested |
| fetch_ack | input | 1 | Fetch data valid this cycle |
| fetch_data | input | 32 | Fetched instruction word |
| issue_valid | output | 1 | Word offered to execution |
| issue_word | output | 32 | Offered instruction word |
| issue_pc | output | AW | Address of the offered word |
| issue_first | output | 1 | Offered word is slot 0 |
| issue_slot | output | SLOT_W | Slot index of the offered word |
| gr0_clr | output | 1 | Zero general register 0 now |
| exec_done | input | 1 | Execution of the offered word finished |
| exec_branch | input | 1 | Next address is exec_target |
| exec_target | input | AW | Branch destination |
| exec_unit | input | 4 | Unit code assigned to the word |
| exec_virtual | input | 1 | Internal word, no cycle cost |
| exec_timed | input | 1 | exec_cycles holds the word's cost |
| exec_cycles | input | CYC_W | Timing-model cycle count |
| cur_pc | output | AW | Program counter |
| media_slot | output | 4 | Last media-unit code in the bundle |
| commit_req | output | 1 | Request deferred write commit |
| commit_ack | input | 1 | Commit finished |
| done | output | 1 | One-cycle bundle completion pulse |
| insn_count | output | CNT_W | Total words issued |
| cycle_count | output | CNT_W | Total cycle cost |

## Verification
The assertions assume the neighbours respect the handshakes. fetch_ack comes only while fetch_req is high, exec_done only while issue_valid is high, and commit_ack only while commit_req is high, each for a single cycle. The response fields are meaningful only alongside exec_done. The stimulus drives every acknowledge from one sequential task that waits for the matching request, holds it one cycle and then drops it. It randomises only the delays, the words and the response fields. Stray start pulses are sent only as a deliberate test of the idle-only rule.

// File: rtl/bseq_pkg.sv
package bseq_pkg;
  localparam int UNIT_W  = 4;
  localparam int END_BIT = 31;

  typedef logic [UNIT_W-1:0] unit_t;

  localparam unit_t UNIT_NONE     = 4'd0;
  localparam unit_t UNIT_MEDIA_LO = 4'd8;
  localparam unit_t UNIT_MEDIA_HI = 4'd11;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_FETCH,
    ST_ISSUE,
    ST_COMMIT,
    ST_DONE
  } seq_state_e;

  function automatic logic unit_is_media(unit_t u);
    return (u >= UNIT_MEDIA_LO) && (u <= UNIT_MEDIA_HI);
  endfunction
endpackage

// File: rtl/bseq_ctrl.sv
module bseq_ctrl
  import bseq_pkg::*;
#(
  parameter int MAX_SLOTS = 4,
  parameter int SLOT_W    = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic              fetch_ack,
  input  logic              fetch_end,
  input  logic              exec_done,
  input  logic              commit_ack,
  output seq_state_e        state,
  output logic [SLOT_W-1:0] slot,
  output logic              first,
  output logic              gr0_pulse,
  output logic              accept,
  output logic              load,
  output logic              step,
  output logic              close
);
  localparam logic [SLOT_W-1:0] LAST_SLOT = SLOT_W'(MAX_SLOTS - 1);

  seq_state_e state_q, state_d;
  logic       end_q;
  logic       stop;

  assign accept = (state_q == ST_IDLE)   && start;
  assign load   = (state_q == ST_FETCH)  && fetch_ack;
  assign step   = (state_q == ST_ISSUE)  && exec_done;
  assign close  = (state_q == ST_COMMIT) && commit_ack;
  assign stop   = end_q || (slot == LAST_SLOT);

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_IDLE:   if (accept) state_d = ST_FETCH;
      ST_FETCH:  if (load)   state_d = ST_ISSUE;
      ST_ISSUE:  if (step)   state_d = stop ? ST_COMMIT : ST_FETCH;
      ST_COMMIT: if (close)  state_d = ST_DONE;
      ST_DONE:               state_d = ST_IDLE;
      default:               state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q   <= ST_IDLE;
      slot      <= '0;
      first     <= 1'b0;
      end_q     <= 1'b0;
      gr0_pulse <= 1'b0;
    end else begin
      state_q   <= state_d;
      gr0_pulse <= load;
      if (accept) begin
        slot  <= '0;
        first <= 1'b1;
      end else if (step) begin
        slot  <= slot + 1'b1;
        first <= 1'b0;
      end
      if (load) end_q <= fetch_end;
    end
  end

  assign state = state_q;
endmodule

// File: rtl/bseq_pc.sv
module bseq_pc #(
  parameter int AW = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          accept,
  input  logic [AW-1:0] start_pc,
  input  logic          step,
  input  logic          branch,
  input  logic [AW-1:0] target,
  output logic [AW-1:0] pc
);
  localparam logic [AW-1:0] WORD_BYTES = AW'(4);

  function automatic logic [AW-1:0] next_addr(logic [AW-1:0] cur, logic br,
                                              logic [AW-1:0] tgt);
    return br ? tgt : cur + WORD_BYTES;
  endfunction

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      pc <= '0;
    else if (accept) pc <= start_pc;
    else if (step)   pc <= next_addr(pc, branch, target);
  end
endmodule

// File: rtl/bseq_media.sv
module bseq_media
  import bseq_pkg::*;
(
  input  logic  clk,
  input  logic  rst_n,
  input  logic  accept,
  input  logic  step,
  input  unit_t unit,
  output unit_t media
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                           media <= UNIT_NONE;
    else if (accept)                      media <= UNIT_NONE;
    else if (step && unit_is_media(unit)) media <= unit;
  end
endmodule

// File: rtl/bseq_tally.sv
module bseq_tally #(
  parameter int CNT_W  = 32,
  parameter int CYC_W  = 4,
  parameter int SLOT_W = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              step,
  input  logic              virt,
  input  logic              timed,
  input  logic [CYC_W-1:0]  cycles,
  input  logic              close,
  input  logic [SLOT_W-1:0] issued,
  output logic [CNT_W-1:0]  insn_total,
  output logic [CNT_W-1:0]  cyc_total
);
  function automatic logic [CNT_W-1:0] word_cost(logic v, logic t,
                                                 logic [CYC_W-1:0] c);
    if (v)      return '0;
    else if (t) return CNT_W'(c);
    else        return CNT_W'(1);
  endfunction

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      insn_total <= '0;
      cyc_total  <= '0;
    end else begin
      if (close) insn_total <= insn_total + CNT_W'(issued);
      if (step)  cyc_total  <= cyc_total + word_cost(virt, timed, cycles);
    end
  end
endmodule

// File: rtl/bundle_seq.sv
module bundle_seq
  import bseq_pkg::*;
#(
  parameter int AW        = 32,
  parameter int MAX_SLOTS = 4,
  parameter int CYC_W     = 4,
  parameter int CNT_W     = 32,
  localparam int SLOT_W   = $clog2(MAX_SLOTS + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [AW-1:0]     start_pc,
  output logic              fetch_req,
  output logic [AW-1:0]     fetch_addr,
  input  logic              fetch_ack,
  input  logic [31:0]       fetch_data,
  output logic              issue_valid,
  output logic [31:0]       issue_word,
  output logic [AW-1:0]     issue_pc,
  output logic              issue_first,
  output logic [SLOT_W-1:0] issue_slot,
  output logic              gr0_clr,
  input  logic              exec_done,
  input  logic              exec_branch,
  input  logic [AW-1:0]     exec_target,
  input  logic [3:0]        exec_unit,
  input  logic              exec_virtual,
  input  logic              exec_timed,
  input  logic [CYC_W-1:0]  exec_cycles,
  output logic [AW-1:0]     cur_pc,
  output logic [3:0]        media_slot,
  output logic              commit_req,
  input  logic              commit_ack,
  output logic              done,
  output logic [CNT_W-1:0]  insn_count,
  output logic [CNT_W-1:0]  cycle_count
);
  seq_state_e        state;
  logic [SLOT_W-1:0] slot;
  logic              first;
  logic              gr0_pulse;
  logic              ev_accept, ev_load, ev_step, ev_close;
  logic [31:0]       word_q;

  bseq_ctrl #(.MAX_SLOTS(MAX_SLOTS), .SLOT_W(SLOT_W)) u_ctrl (
    .clk(clk), .rst_n(rst_n), .start(start), .fetch_ack(fetch_ack),
    .fetch_end(fetch_data[END_BIT]), .exec_done(exec_done),
    .commit_ack(commit_ack), .state(state), .slot(slot), .first(first),
    .gr0_pulse(gr0_pulse), .accept(ev_accept), .load(ev_load),
    .step(ev_step), .close(ev_close)
  );

  bseq_pc #(.AW(AW)) u_pc (
    .clk(clk), .rst_n(rst_n), .accept(ev_accept), .start_pc(start_pc),
    .step(ev_step), .branch(exec_branch), .target(exec_target), .pc(cur_pc)
  );

  bseq_media u_media (
    .clk(clk), .rst_n(rst_n), .accept(ev_accept), .step(ev_step),
    .unit(exec_unit), .media(media_slot)
  );

  bseq_tally #(.CNT_W(CNT_W), .CYC_W(CYC_W), .SLOT_W(SLOT_W)) u_tally (
    .clk(clk), .rst_n(rst_n), .step(ev_step), .virt(exec_virtual),
    .timed(exec_timed), .cycles(exec_cycles), .close(ev_close),
    .issued(slot), .insn_total(insn_count), .cyc_total(cycle_count)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       word_q <= '0;
    else if (ev_load) word_q <= fetch_data;
  end

  assign fetch_req   = (state == ST_FETCH);
  assign fetch_addr  = cur_pc;
  assign issue_valid = (state == ST_ISSUE);
  assign issue_word  = word_q;
  assign issue_pc    = cur_pc;
  assign issue_first = first;
  assign issue_slot  = slot;
  assign gr0_clr     = gr0_pulse;
  assign commit_req  = (state == ST_COMMIT);
  assign done        = (state == ST_DONE);
endmodule

// File: rtl/bseq_checker.sv
module bseq_checker
  import bseq_pkg::*;
#(
  parameter int MAX_SLOTS = 4,
  parameter int SLOT_W    = 3,
  parameter int CNT_W     = 32
) (
  input logic              clk,
  input logic              rst_n,
  input logic              fetch_req,
  input logic              issue_valid,
  input logic              issue_first,
  input logic [SLOT_W-1:0] issue_slot,
  input logic              issue_end,
  input logic              gr0_clr,
  input logic              exec_done,
  input logic              exec_virtual,
  input logic              commit_req,
  input logic              commit_ack,
  input logic              done,
  input logic [CNT_W-1:0]  cycle_count,
  input logic [3:0]        media_slot
);
  assert_single_owner_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !(fetch_req && issue_valid));

  assert_end_closes_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (issue_valid && exec_done && issue_end) |=> commit_req);

  assert_slot_cap_R4: assert property (@(posedge clk) disable iff (!rst_n)
    issue_valid |-> (32'(issue_slot) < MAX_SLOTS));

  assert_first_mark_R5: assert property (@(posedge clk) disable iff (!rst_n)
    issue_valid |-> (issue_first == (issue_slot == '0)));

  assert_gr0_lead_R6: assert property (@(posedge clk) disable iff (!rst_n)
    gr0_clr |-> (issue_valid && !$past(issue_valid)));

  assert_media_code_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (media_slot == UNIT_NONE) || unit_is_media(media_slot));

  assert_done_after_commit_R9: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> $past(commit_req && commit_ack));

  assert_virtual_free_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (issue_valid && exec_done && exec_virtual) |=> $stable(cycle_count));
endmodule

bind bundle_seq bseq_checker #(
  .MAX_SLOTS(MAX_SLOTS), .SLOT_W(SLOT_W), .CNT_W(CNT_W)
) u_bseq_checker (
  .clk(clk), .rst_n(rst_n), .fetch_req(fetch_req), .issue_valid(issue_valid),
  .issue_first(issue_first), .issue_slot(issue_slot),
  .issue_end(issue_word[31]), .gr0_clr(gr0_clr), .exec_done(exec_done),
  .exec_virtual(exec_virtual), .commit_req(commit_req),
  .commit_ack(commit_ack), .done(done), .cycle_count(cycle_count),
  .media_slot(media_slot)
);

// File: tb/bundle_seq_bench.sv
`timescale 1ns/1ps
module bundle_seq_bench;
  localparam int AW = 32, MAXS = 4, CYC_W = 4, CNT_W = 32;
  localparam int SLOT_W = $clog2(MAXS + 1);

  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic              rst_n, start, fetch_req, fetch_ack, issue_valid, issue_first;
  logic [AW-1:0]     start_pc, fetch_addr, issue_pc, exec_target, cur_pc;
  logic [31:0]       fetch_data, issue_word;
  logic [SLOT_W-1:0] issue_slot;
  logic              gr0_clr, exec_done, exec_branch, exec_virtual, exec_timed;
  logic [3:0]        exec_unit, media_slot;
  logic [CYC_W-1:0]  exec_cycles;
  logic              commit_req, commit_ack, done;
  logic [CNT_W-1:0]  insn_count, cycle_count;

  bundle_seq #(.AW(AW), .MAX_SLOTS(MAXS), .CYC_W(CYC_W), .CNT_W(CNT_W)) u_bundle_seq (
    .clk(clk), .rst_n(rst_n), .start(start), .start_pc(start_pc),
    .fetch_req(fetch_req), .fetch_addr(fetch_addr), .fetch_ack(fetch_ack),
    .fetch_data(fetch_data), .issue_valid(issue_valid), .issue_word(issue_word),
    .issue_pc(issue_pc), .issue_first(issue_first), .issue_slot(issue_slot),
    .gr0_clr(gr0_clr), .exec_done(exec_done), .exec_branch(exec_branch),
    .exec_target(exec_target), .exec_unit(exec_unit), .exec_virtual(exec_virtual),
    .exec_timed(exec_timed), .exec_cycles(exec_cycles), .cur_pc(cur_pc),
    .media_slot(media_slot), .commit_req(commit_req), .commit_ack(commit_ack),
    .done(done), .insn_count(insn_count), .cycle_count(cycle_count)
  );

  int checks = 0, errors = 0;
  bit finished = 1'b0;
  logic [31:0] mem [64];
  logic [31:0] exp_insn = 0, exp_cyc = 0;

  function automatic logic [31:0] cost_of(logic v, logic t, logic [3:0] c);
    if (v) return 0;
    if (t) return 32'(c);
    return 1;
  endfunction

  function automatic bit media_code(logic [3:0] u);
    return (u >= 4'd8) && (u <= 4'd11);
  endfunction

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // word_mode: 0 as stored, 1 end bit cleared, 2 end bit set
  // resp_mode: 0 random unit, 1 media units only, 2 non-media units only
  task automatic run_bundle(logic [31:0] pc0, int word_mode, int resp_mode, bit poke);
    logic [31:0] exp_pc, w, tgt;
    logic [3:0] exp_media, unit, cyc;
    logic br, virt, timed, last;
    int n;
    @(negedge clk);
    start = 1'b1; start_pc = pc0;
    @(negedge clk);
    start = 1'b0; start_pc = '0;
    exp_pc = pc0; exp_media = 4'd0; n = 0; last = 1'b0;
    while (!last) begin
      for (int g = 0; g < 50 && !fetch_req; g++) @(negedge clk);
      chk("R2 fetch_req", 32'(fetch_req), 1);
      chk("R2 fetch_addr", fetch_addr, exp_pc);
      w = mem[exp_pc[7:2]];
      if (word_mode == 1) w[31] = 1'b0;
      if (word_mode == 2) w[31] = 1'b1;
      fetch_ack = 1'b1; fetch_data = w;
      @(negedge clk);
      fetch_ack = 1'b0; fetch_data = $urandom;
      chk("R2 issue_valid", 32'(issue_valid), 1);
      chk("R2 issue_word", issue_word, w);
      chk("R2 issue_pc", issue_pc, exp_pc);
      chk("R6 gr0_clr at issue", 32'(gr0_clr), 1);
      chk("R5 issue_first", 32'(issue_first), 32'(n == 0));
      chk("R4 issue_slot", 32'(issue_slot), n);
      for (int d = $urandom_range(0, 2); d > 0; d--) begin
        if (poke) begin start = 1'b1; start_pc = 32'hF0; end
        @(negedge clk);
        start = 1'b0; start_pc = '0;
        chk("R6 gr0_clr after first cycle", 32'(gr0_clr), 0);
      end
      br = ($urandom_range(0, 3) == 0);
      tgt = {24'd0, 6'($urandom_range(0, 63)), 2'b00};
      case (resp_mode)
        1: unit = 4'(8 + $urandom_range(0, 3));
        2: unit = 4'($urandom_range(0, 7));
        default: unit = 4'($urandom_range(0, 15));
      endcase
      virt = ($urandom_range(0, 4) == 0);
      timed = 1'($urandom_range(0, 1));
      cyc = 4'($urandom_range(0, 15));
      exec_done = 1'b1; exec_branch = br; exec_target = tgt; exec_unit = unit;
      exec_virtual = virt; exec_timed = timed; exec_cycles = cyc;
      @(negedge clk);
      exec_done = 1'b0; exec_branch = 1'b0; exec_unit = '0;
      exp_cyc += cost_of(virt, timed, cyc);
      if (media_code(unit)) exp_media = unit;
      exp_pc = br ? tgt : exp_pc + 4;
      n++;
      chk("R8 cur_pc", cur_pc, exp_pc);
      chk("R10 cycle_count", cycle_count, exp_cyc);
      last = w[31] || (n == MAXS);
      if (last) begin
        chk(w[31] ? "R3 commit after end bit" : "R4 commit at slot limit",
            32'(commit_req), 1);
        chk("R3 no fetch at close", 32'(fetch_req), 0);
      end else begin
        chk("R3 fetch continues", 32'(fetch_req), 1);
        chk("R3 no early commit", 32'(commit_req), 0);
      end
    end
    repeat ($urandom_range(0, 2)) @(negedge clk);
    commit_ack = 1'b1;
    @(negedge clk);
    commit_ack = 1'b0;
    exp_insn += 32'(n);
    chk("R9 done pulse", 32'(done), 1);
    chk("R9 insn_count", insn_count, exp_insn);
    chk("R10 cycle_count at close", cycle_count, exp_cyc);
    chk("R7 media_slot", 32'(media_slot), 32'(exp_media));
    if (poke) begin start = 1'b1; start_pc = 32'hE0; end
    @(negedge clk);
    start = 1'b0; start_pc = '0;
    chk("R9 done one cycle", 32'(done), 0);
    chk("R11 start ignored in done cycle", 32'(fetch_req), 0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      errors++;
      $display("FAIL R9 watchdog expired actual=running expected=finished");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd2718));
    rst_n = 1'b0; start = 1'b0; start_pc = '0; fetch_ack = 1'b0; fetch_data = '0;
    exec_done = 1'b0; exec_branch = 1'b0; exec_target = '0; exec_unit = '0;
    exec_virtual = 1'b0; exec_timed = 1'b0; exec_cycles = '0; commit_ack = 1'b0;
    for (int i = 0; i < 64; i++) mem[i] = $urandom;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 fetch_req", 32'(fetch_req), 0);
    chk("R1 issue_valid", 32'(issue_valid), 0);
    chk("R1 commit_req", 32'(commit_req), 0);
    chk("R1 done", 32'(done), 0);
    chk("R1 gr0_clr", 32'(gr0_clr), 0);
    chk("R1 insn_count", insn_count, 0);
    chk("R1 cycle_count", cycle_count, 0);
    chk("R1 media_slot", 32'(media_slot), 0);
    run_bundle(32'h10, 1, 1, 1'b0);
    run_bundle(32'h40, 2, 2, 1'b1);
    run_bundle(32'hFC, 1, 0, 1'b1);
    for (int b = 0; b < 40; b++)
      run_bundle({24'd0, 6'($urandom_range(0, 63)), 2'b00}, 0,
                 $urandom_range(0, 2), 1'($urandom_range(0, 1)));
    finished = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule